// File: doc/BRIEF.md
# SD Host Register Access Adapter

The adapter sits between a host bus that issues byte, halfword and word register accesses and an SD host controller register file that accepts only whole, aligned 32-bit accesses. Each host access is turned into zero, one or two backend cycles. Narrow reads pick a lane out of the aligned word. Narrow writes become a read-modify-write of that word.

On top of lane merging, the adapter performs four conversions. It re-encodes the SD clock divisor between the standard split field layout and the flat binary divisor used by the backend. It holds the transfer-mode halfword in a shadow until the command halfword arrives, then writes both as one word. It can clear the high-speed capability bit when reporting capabilities. It can force the card-present status bit when reporting present state.

The host side uses a valid/ready request and a one-cycle acknowledge. The backend side holds a request until the backend acknowledges it. Only one host access is in flight at a time.

Top module: `sdreg_bridge`

## Requirements
- R1: A byte (size 0) or halfword (size 1) read returns, right-justified in h_rdata, the aligned backend word shifted right by 8 × addr[1:0] and masked to 8 or 16 bits.
- R2: A byte or halfword write (value right-justified in h_wdata) reads the aligned word, replaces only the addressed lane and writes the whole word back. A word write (size 2) is a single backend write of h_wdata.
- R3: A halfword read at offset 0x2C returns a 16-bit value built from the backend divisor D in bits 15..6. With Q = D/2 (rounded down): bits 15..8 = Q[7:0], bits 7..6 = Q[9:8] when spec3 is 1 and 0 otherwise, bits 5..0 = backend bits 5..0.
- R4: A halfword write at 0x2C forms N = {spec3 ? v[7:6] : 0, v[15:8]}. It writes 2N clamped to 1023 into backend bits 15..6 and v[5:0] into bits 5..0, and keeps backend bits 31..16.
- R5: A halfword write at 0x0C (transfer mode) updates only the low half of the shadow and issues no backend cycle.
- R6: A halfword write at 0x0E (command) sets the shadow high half and issues exactly one backend write of {command, transfer-mode} to word address 0x0C.
- R7: Halfword reads at 0x0C and 0x0E return the shadow low and high halves and issue no backend cycle.
- R8: A word read at 0x40 returns bit 21 cleared when hs_disable is 1 and unchanged otherwise. Narrow reads there are not altered.
- R9: A word read at 0x24 returns bit 16 set when force_present is 1 and unchanged otherwise.
- R10: h_ready is low from acceptance until the acknowledge. h_ack is a single-cycle pulse one cycle after the last backend cycle, or one cycle after acceptance when no backend cycle is needed.
- R11: A halfword access with addr[1:0] = 3 is acknowledged with h_err = 1 and issues no backend cycle.
- R12: After reset, h_ready is 1, h_ack is 0, b_req is 0 and the shadow reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spec3 | input | 1 | Use the two-field (10-bit) standard divisor layout |
| hs_disable | input | 1 | Clear the high-speed capability bit on reads |
| force_present | input | 1 | Force the card-present status bit on reads |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Adapter idle and able to accept |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word |
| h_addr | input | AW | Byte address |
| h_wdata | input | 32 | Write value, right-justified |
| h_ack | output | 1 | Access complete (one cycle) |
| h_rdata | output | 32 | Read value, right-justified |
| h_err | output | 1 | Access rejected (misaligned) |
| b_req | output | 1 | Backend cycle request, held until b_ack |
| b_we | output | 1 | Backend write |
| b_addr | output | AW | Backend word-aligned address |
| b_wdata | output | 32 | Backend write word |
| b_ack | input | 1 | Backend cycle done |
| b_rdata | input | 32 | Backend read word, valid with b_ack |

## Verification
A command halfword write updates the shadow and launches the combined backend write in the cycle after acceptance. The written word must therefore already carry the new command half next to the held transfer-mode half. The bench writes the transfer-mode half, then the command half. It judges the result by the backend write count, the backend word read back whole, and shadow reads of both halves. The clock-control write also performs lane preservation and divisor re-encoding in the same backend cycle. That case is judged by reading the whole word back under both spec3 settings, including the clamp.

// File: rtl/sdreg_bridge.sv
module sdreg_bridge #(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFF_XFER = 8'h0C,
  parameter logic [AW-1:0] OFF_CLK  = 8'h2C,
  parameter logic [AW-1:0] OFF_PRES = 8'h24,
  parameter logic [AW-1:0] OFF_CAPS = 8'h40,
  parameter int HS_BIT = 21,
  parameter int CP_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec3,
  input  logic          hs_disable,
  input  logic          force_present,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_we,
  input  logic [1:0]    h_size,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic          h_ack,
  output logic [31:0]   h_rdata,
  output logic          h_err,
  output logic          b_req,
  output logic          b_we,
  output logic [AW-1:0] b_addr,
  output logic [31:0]   b_wdata,
  input  logic          b_ack,
  input  logic [31:0]   b_rdata
);
  localparam logic [AW-1:0] OFF_CMD = OFF_XFER + AW'(2);
  localparam logic [10:0]   DIV_MAX = 11'd1023;
  localparam logic [1:0]    SZ_BYTE = 2'd0;
  localparam logic [1:0]    SZ_HALF = 2'd1;

  typedef enum logic [1:0] {IDLE, RD, WR, DONE} st_t;
  st_t st;

  logic          we_q, err_q;
  logic [1:0]    size_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rdata_q, shadow;

  logic [4:0]    sh;
  logic [31:0]   rsh, lmask, lins, merged, rfmt, wpatch;
  logic [9:0]    dq, dclamp;
  logic [10:0]   dsum;
  logic [15:0]   clk_rd;
  logic [AW-1:0] waddr;
  logic          is_clk, h_half, h_shadow;

  assign h_ready = (st == IDLE);
  assign h_ack   = (st == DONE);
  assign h_rdata = rdata_q;
  assign h_err   = err_q;
  assign b_req   = (st == RD) || (st == WR);
  assign b_we    = (st == WR);
  assign waddr   = {addr_q[AW-1:2], 2'b00};
  assign b_addr  = waddr;
  assign b_wdata = wdata_q;

  assign h_half   = (h_size == SZ_HALF);
  assign h_shadow = h_half && (h_addr == OFF_XFER || h_addr == OFF_CMD);

  assign sh     = {addr_q[1:0], 3'b000};
  assign rsh    = b_rdata >> sh;
  assign is_clk = (size_q == SZ_HALF) && (addr_q == OFF_CLK);

  assign dq     = {1'b0, b_rdata[15:7]};
  assign clk_rd = {dq[7:0], spec3 ? dq[9:8] : 2'b00, b_rdata[5:0]};
  assign dsum   = {1'b0, spec3 ? wdata_q[7:6] : 2'b00, wdata_q[15:8]} << 1;
  assign dclamp = (dsum > DIV_MAX) ? DIV_MAX[9:0] : dsum[9:0];

  always_comb begin
    wpatch = b_rdata;
    if (waddr == OFF_CAPS && hs_disable) wpatch[HS_BIT] = 1'b0;
    if (waddr == OFF_PRES && force_present) wpatch[CP_BIT] = 1'b1;
    case (size_q)
      SZ_BYTE: rfmt = {24'h0, rsh[7:0]};
      SZ_HALF: rfmt = is_clk ? {16'h0, clk_rd} : {16'h0, rsh[15:0]};
      default: rfmt = wpatch;
    endcase
  end

  always_comb begin
    if (size_q == SZ_BYTE) begin
      lmask = 32'h0000_00FF << sh;
      lins  = {24'h0, wdata_q[7:0]} << sh;
    end else begin
      lmask = 32'h0000_FFFF << sh;
      lins  = {16'h0, wdata_q[15:0]} << sh;
    end
    merged = is_clk ? {b_rdata[31:16], dclamp, wdata_q[5:0]}
                    : ((b_rdata & ~lmask) | lins);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= '0;
      wdata_q <= 32'h0;
      rdata_q <= 32'h0;
      shadow  <= 32'h0;
    end else begin
      case (st)
        IDLE: if (h_valid) begin
          we_q    <= h_we;
          size_q  <= h_size;
          addr_q  <= h_addr;
          wdata_q <= h_wdata;
          err_q   <= 1'b0;
          if (h_half && h_addr[1:0] == 2'b11) begin
            err_q <= 1'b1;
            st    <= DONE;
          end else if (h_shadow) begin
            if (!h_we) begin
              rdata_q <= {16'h0, (h_addr == OFF_XFER) ? shadow[15:0] : shadow[31:16]};
              st      <= DONE;
            end else if (h_addr == OFF_XFER) begin
              shadow[15:0] <= h_wdata[15:0];
              st           <= DONE;
            end else begin
              shadow[31:16] <= h_wdata[15:0];
              wdata_q       <= {h_wdata[15:0], shadow[15:0]};
              addr_q        <= OFF_XFER;
              st            <= WR;
            end
          end else if (h_we && h_size != SZ_BYTE && !h_half) begin
            st <= WR;
          end else begin
            st <= RD;
          end
        end
        RD: if (b_ack) begin
          if (we_q) begin
            wdata_q <= merged;
            st      <= WR;
          end else begin
            rdata_q <= rfmt;
            st      <= DONE;
          end
        end
        WR: if (b_ack) st <= DONE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdreg_bridge_chk.sv
module sdreg_bridge_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFF_XFER = 8'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_valid,
  input logic          h_ready,
  input logic          h_we,
  input logic [1:0]    h_size,
  input logic [AW-1:0] h_addr,
  input logic [31:0]   h_wdata,
  input logic          h_ack,
  input logic          h_err,
  input logic          b_req,
  input logic          b_we,
  input logic [AW-1:0] b_addr,
  input logic [31:0]   b_wdata,
  input logic          b_ack
);
  logic acc, acc_half;
  assign acc      = h_valid && h_ready;
  assign acc_half = acc && (h_size == 2'd1);

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> !h_ack);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !h_ready);

  // R10
  no_ack_during_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_req |-> (!h_ready && !h_ack));

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !b_ack) |=> (b_req && $stable(b_addr) && $stable(b_we) && $stable(b_wdata)));

  // R2
  aligned_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_req |-> (b_addr[1:0] == 2'b00));

  // R11
  misaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_half && h_addr[1:0] == 2'b11) |=> (h_ack && h_err && !b_req));

  // R5
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_half && h_we && h_addr == OFF_XFER) |=> (h_ack && !b_req));

  // R6
  cmd_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_half && h_we && h_addr == OFF_XFER + AW'(2)) |=>
      (b_req && b_we && b_addr == OFF_XFER && b_wdata[31:16] == $past(h_wdata[15:0])));

  // R7
  shadow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_half && !h_we && (h_addr == OFF_XFER || h_addr == OFF_XFER + AW'(2))) |=>
      (h_ack && !h_err && !b_req));
endmodule

bind sdreg_bridge sdreg_bridge_chk #(.AW(AW), .OFF_XFER(OFF_XFER)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we),
  .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata), .h_ack(h_ack), .h_err(h_err),
  .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_ack(b_ack)
);

// File: tb/sim_sdreg_bridge.sv
module sim_sdreg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spec3 = 1'b0, hs_disable = 1'b0, force_present = 1'b0;
  logic h_valid = 1'b0, h_we = 1'b0;
  logic [1:0] h_size = 2'd0;
  logic [AW-1:0] h_addr = '0;
  logic [31:0] h_wdata = 32'h0;
  logic h_ready, h_ack, h_err, b_req, b_we, b_ack;
  logic [AW-1:0] b_addr;
  logic [31:0] b_wdata, b_rdata;

  logic [31:0] mem [64];
  int wr_cnt = 0, rd_cnt = 0;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdreg_bridge #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .spec3(spec3), .hs_disable(hs_disable),
    .force_present(force_present), .h_valid(h_valid), .h_ready(h_ready),
    .h_we(h_we), .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ack(h_ack), .h_rdata(), .h_err(h_err), .b_req(b_req), .b_we(b_we),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_ack(b_ack), .b_rdata(b_rdata)
  );

  logic [31:0] h_rdata;
  assign h_rdata = u0.h_rdata;

  assign b_ack   = b_req;
  assign b_rdata = mem[b_addr[7:2]];

  always_ff @(posedge clk) begin
    if (b_req && b_ack) begin
      if (b_we) begin
        mem[b_addr[7:2]] <= b_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic er;
  int lat;

  task automatic acc(input logic we, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] wd);
    @(negedge clk);
    h_valid = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
    @(posedge clk);
    #1 h_valid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!h_ack && lat < 50);
    if (!h_ack) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL R10 no acknowledge: actual=0 expected=1");
    end
    rd = h_rdata;
    er = h_err;
  endtask

  // {we, size, addr, wdata, expected read}
  localparam logic [74:0] VEC [10] = '{
    {1'b1, 2'd2, 8'h10, 32'h1122_3344, 32'h0},
    {1'b0, 2'd2, 8'h10, 32'h0,         32'h1122_3344},
    {1'b0, 2'd0, 8'h11, 32'h0,         32'h0000_0033},
    {1'b0, 2'd0, 8'h13, 32'h0,         32'h0000_0011},
    {1'b0, 2'd1, 8'h12, 32'h0,         32'h0000_1122},
    {1'b1, 2'd0, 8'h12, 32'h0000_00AB, 32'h0},
    {1'b0, 2'd2, 8'h10, 32'h0,         32'h11AB_3344},
    {1'b1, 2'd1, 8'h10, 32'h0000_BEEF, 32'h0},
    {1'b0, 2'd2, 8'h10, 32'h0,         32'h11AB_BEEF},
    {1'b0, 2'd1, 8'h11, 32'h0,         32'h0000_ABBE}
  };

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    // R12
    chk("R12 h_ready in reset", {31'h0, h_ready}, 32'h1);
    chk("R12 h_ack in reset", {31'h0, h_ack}, 32'h0);
    chk("R12 b_req in reset", {31'h0, b_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 2'd1, 8'h0C, 32'h0);
    chk("R12 shadow low after reset", rd, 32'h0);

    for (int i = 0; i < 10; i++) begin
      acc(VEC[i][74], VEC[i][73:72], VEC[i][71:64], VEC[i][63:32]);
      if (!VEC[i][74]) chk(VEC[i][73:72] == 2'd2 ? "R2 word readback" : "R1 narrow read", rd, VEC[i][31:0]);
    end

    // R10 latencies
    acc(1'b0, 2'd2, 8'h10, 32'h0);
    chk("R10 word read latency", lat, 2);
    acc(1'b1, 2'd0, 8'h10, 32'h0000_0055);
    chk("R10 read-modify-write latency", lat, 3);
    w0 = wr_cnt;
    acc(1'b1, 2'd2, 8'h14, 32'hA5A5_5A5A);
    chk("R2 word write single backend write", wr_cnt - w0, 1);

    // R4 / R3 clock control
    acc(1'b1, 2'd2, 8'h2C, 32'hCAFE_0000);
    spec3 = 1'b1;
    acc(1'b1, 2'd1, 8'h2C, 32'h0000_0595);
    acc(1'b0, 2'd2, 8'h2C, 32'h0);
    chk("R4 clamp spec3", rd, 32'hCAFE_FFD5);
    acc(1'b0, 2'd1, 8'h2C, 32'h0);
    chk("R3 read spec3 div 1023", rd, 32'h0000_FF55);
    spec3 = 1'b0;
    acc(1'b0, 2'd1, 8'h2C, 32'h0);
    chk("R3 read no spec3 div 1023", rd, 32'h0000_FF15);
    acc(1'b1, 2'd1, 8'h2C, 32'h0000_0595);
    acc(1'b0, 2'd2, 8'h2C, 32'h0);
    chk("R4 write no spec3", rd, 32'hCAFE_0295);
    acc(1'b0, 2'd1, 8'h2C, 32'h0);
    chk("R3 read divisor 10", rd, 32'h0000_0515);
    acc(1'b1, 2'd2, 8'h2C, 32'h0000_0040);
    acc(1'b0, 2'd1, 8'h2C, 32'h0);
    chk("R3 divisor 1 reads 0", rd, 32'h0000_0000);

    // R5 R6 R7 shadow
    acc(1'b1, 2'd2, 8'h0C, 32'h0);
    w0 = wr_cnt;
    acc(1'b1, 2'd1, 8'h0C, 32'h0000_1234);
    chk("R5 no backend write", wr_cnt - w0, 0);
    acc(1'b0, 2'd2, 8'h0C, 32'h0);
    chk("R5 backend word untouched", rd, 32'h0);
    r0 = rd_cnt;
    acc(1'b0, 2'd1, 8'h0C, 32'h0);
    chk("R7 shadow low read", rd, 32'h0000_1234);
    chk("R7 no backend read", rd_cnt - r0, 0);
    w0 = wr_cnt;
    acc(1'b1, 2'd1, 8'h0E, 32'h0000_5678);
    chk("R6 one backend write", wr_cnt - w0, 1);
    acc(1'b0, 2'd2, 8'h0C, 32'h0);
    chk("R6 combined word", rd, 32'h5678_1234);
    acc(1'b0, 2'd1, 8'h0E, 32'h0);
    chk("R7 shadow high read", rd, 32'h0000_5678);

    // R8 R9 patches
    acc(1'b1, 2'd2, 8'h40, 32'hFFFF_FFFF);
    hs_disable = 1'b1;
    acc(1'b0, 2'd2, 8'h40, 32'h0);
    chk("R8 high-speed cleared", rd, 32'hFFDF_FFFF);
    acc(1'b0, 2'd0, 8'h42, 32'h0);
    chk("R8 byte read not patched", rd, 32'h0000_00FF);
    hs_disable = 1'b0;
    acc(1'b0, 2'd2, 8'h40, 32'h0);
    chk("R8 no patch when off", rd, 32'hFFFF_FFFF);
    acc(1'b1, 2'd2, 8'h24, 32'h0);
    force_present = 1'b1;
    acc(1'b0, 2'd2, 8'h24, 32'h0);
    chk("R9 present forced", rd, 32'h0001_0000);
    force_present = 1'b0;
    acc(1'b0, 2'd2, 8'h24, 32'h0);
    chk("R9 no force when off", rd, 32'h0);

    // R11 misaligned
    w0 = wr_cnt; r0 = rd_cnt;
    acc(1'b1, 2'd1, 8'h13, 32'h0000_0000);
    chk("R11 write error flag", {31'h0, er}, 32'h1);
    chk("R11 no backend cycle", (wr_cnt - w0) + (rd_cnt - r0), 0);
    acc(1'b0, 2'd1, 8'h13, 32'h0);
    chk("R11 read error flag", {31'h0, er}, 32'h1);
    acc(1'b0, 2'd2, 8'h10, 32'h0);
    chk("R11 word unchanged", rd, 32'h11AB_BE55);
    chk("R11 error cleared on next access", {31'h0, er}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule